// File: doc/BRIEF.md
# Audio Bit and Frame Clock Divider

This block runs on a fixed master clock and derives from it the serial audio bit clock and the left/right frame clock by integer division. The bit clock is always 64 times the frame rate, so a master clock held at one frequency serves two sample rates: with the slow rate code the master clock is 512 times the frame rate (8 master cycles per bit clock), with the fast rate code it is 256 times the frame rate (4 master cycles per bit clock). A 24.576 MHz master clock thus gives 48 kHz or 96 kHz frames.

The rate code may be flipped between its two legal values while the clocks run. The new division is taken up only where one frame ends and the next begins, so every frame is whole and both clocks stay continuous. Any other change of the code is flagged on a sticky error output; the divider keeps the last legal rate meanwhile.

Top module: `aud_clk_div`

## Requirements
- R1: While rst_ni is low, bck_o, lrck_o and mode_err_o are all 0 and the divider restarts in the 512fs rate.
- R2: With rate code 2'b10 (512fs) the bit clock has a period of 8 master cycles, 4 high and 4 low.
- R3: With rate code 2'b11 (256fs) the bit clock has a period of 4 master cycles, 2 high and 2 low.
- R4: One frame is 64 bit clock periods; lrck_o is low (left) for the first 32 and high (right) for the last 32.
- R5: lrck_o changes only in the master cycle in which bck_o falls.
- R6: A switch between codes 2'b10 and 2'b11 made mid-frame lets the current frame finish at the old length; the next frame, starting at the falling edge of lrck_o, runs at the new length.
- R7: Changes between codes 2'b10 and 2'b11 never set mode_err_o.
- R8: Any change of rate_mode_i that is not between 2'b10 and 2'b11 sets mode_err_o one master cycle later; while the code is illegal (bit 1 clear) the last legal rate stays in use.
- R9: mode_err_o stays set through further illegal changes and clears one cycle after the code changes to a legal value, which is then taken up at the next frame boundary.
- R10: Asserting rst_ni low clears mode_err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_mode_i | input | 2 | Rate code: 2'b10 = 512fs, 2'b11 = 256fs, others illegal |
| bck_o | output | 1 | Bit clock, 64 periods per frame |
| lrck_o | output | 1 | Frame clock, low = left, high = right |
| mode_err_o | output | 1 | Sticky illegal rate-change flag |

## Verification
Whole frames are measured at both rates, recording the low and high lengths of the frame clock, the number of bit clock rises and the shortest and longest bit clock high run, which separates a wrong divide ratio from an uneven duty cycle or a skewed frame. Rate switches are made in the middle of a frame in both directions, so a divider that applies the new ratio at once shows up as a frame of mixed length. Illegal codes are entered from each legal rate, so holding the last rate is told apart from falling back to a default, and the error flag is followed through a second illegal change, a legal reload and a reset.

// File: rtl/aud_clk_div_pkg.sv
package aud_clk_div_pkg;

  typedef enum logic {
    RATE_512 = 1'b0,
    RATE_256 = 1'b1
  } rate_e;

  localparam logic [1:0] CODE_512 = 2'b10;
  localparam logic [1:0] CODE_256 = 2'b11;

  function automatic logic code_legal(input logic [1:0] code);
    return code[1];
  endfunction

  function automatic rate_e code_rate(input logic [1:0] code);
    return (code == CODE_256) ? RATE_256 : RATE_512;
  endfunction

endpackage

// File: rtl/aud_rate_ctrl.sv
module aud_rate_ctrl
  import aud_clk_div_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] rate_mode_i,
  input  logic       frame_end_i,
  output rate_e      rate_o,
  output logic       err_o
);

  logic [1:0] code_q;
  rate_e      pend_q;
  rate_e      rate_q;
  logic       err_q;
  logic       changed;
  logic       new_ok;
  logic       old_ok;

  assign changed = (rate_mode_i != code_q);
  assign new_ok  = code_legal(rate_mode_i);
  assign old_ok  = code_legal(code_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= CODE_512;
      pend_q <= RATE_512;
      rate_q <= RATE_512;
      err_q  <= 1'b0;
    end else begin
      code_q <= rate_mode_i;
      if (changed) begin
        if (new_ok) pend_q <= code_rate(rate_mode_i);
        if (!new_ok)     err_q <= 1'b1;
        else if (!old_ok) err_q <= 1'b0;  // legal reload
      end
      // new ratio only between frames
      if (frame_end_i) rate_q <= pend_q;
    end
  end

  assign rate_o = rate_q;
  assign err_o  = err_q;

  p_rate_at_boundary_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_q != $past(rate_q)) |-> $past(frame_end_i));

  p_no_err_on_toggle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_legal(rate_mode_i) && code_legal(code_q) && !err_q) |=> !err_q);

  p_err_rise_illegal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> !code_legal($past(rate_mode_i)));

  p_err_fall_legal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_q) |-> code_legal($past(rate_mode_i)));

endmodule

// File: rtl/aud_bck_gen.sv
module aud_bck_gen
  import aud_clk_div_pkg::*;
#(
  parameter int unsigned DIV_SLOW = 8,
  parameter int unsigned DIV_FAST = 4
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  rate_e rate_i,
  output logic  bit_end_o,
  output logic  bck_hi_o
);

  localparam int unsigned PC_W = (DIV_SLOW > 2) ? $clog2(DIV_SLOW) : 1;

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] last;
  logic [PC_W-1:0] half;

  always_comb begin
    if (rate_i == RATE_256) begin
      last = PC_W'(DIV_FAST - 1);
      half = PC_W'(DIV_FAST / 2);
    end else begin
      last = PC_W'(DIV_SLOW - 1);
      half = PC_W'(DIV_SLOW / 2);
    end
  end

  assign bit_end_o = (pc_q == last);
  assign bck_hi_o  = (pc_q >= half);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pc_q <= '0;
    else if (bit_end_o) pc_q <= '0;
    else                pc_q <= pc_q + 1'b1;
  end

  p_pc_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_q <= last);

endmodule

// File: rtl/aud_frame_gen.sv
module aud_frame_gen #(
  parameter int unsigned BITS_PER_FRAME = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_end_i,
  input  logic bck_hi_i,
  output logic frame_end_o,
  output logic bck_o,
  output logic lrck_o
);

  localparam int unsigned BC_W = $clog2(BITS_PER_FRAME);
  localparam int unsigned HALF = BITS_PER_FRAME / 2;

  logic [BC_W-1:0] bc_q;

  assign frame_end_o = bit_end_i && (bc_q == BC_W'(BITS_PER_FRAME - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bc_q   <= '0;
      bck_o  <= 1'b0;
      lrck_o <= 1'b0;
    end else begin
      if (frame_end_o)    bc_q <= '0;
      else if (bit_end_i) bc_q <= bc_q + 1'b1;
      // both outputs retimed together so edges stay aligned
      bck_o  <= bck_hi_i;
      lrck_o <= (bc_q >= BC_W'(HALF));
    end
  end

  p_lrck_on_bck_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lrck_o != $past(lrck_o)) |-> ($past(bck_o) && !bck_o));

endmodule

// File: rtl/aud_clk_div.sv
module aud_clk_div
  import aud_clk_div_pkg::*;
#(
  parameter int unsigned DIV_SLOW       = 8,
  parameter int unsigned DIV_FAST       = 4,
  parameter int unsigned BITS_PER_FRAME = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] rate_mode_i,
  output logic       bck_o,
  output logic       lrck_o,
  output logic       mode_err_o
);

  rate_e rate;
  logic  bit_end;
  logic  bck_hi;
  logic  frame_end;

  aud_rate_ctrl u_rate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rate_mode_i(rate_mode_i),
    .frame_end_i(frame_end),
    .rate_o     (rate),
    .err_o      (mode_err_o)
  );

  aud_bck_gen #(
    .DIV_SLOW(DIV_SLOW),
    .DIV_FAST(DIV_FAST)
  ) u_bck (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rate_i   (rate),
    .bit_end_o(bit_end),
    .bck_hi_o (bck_hi)
  );

  aud_frame_gen #(
    .BITS_PER_FRAME(BITS_PER_FRAME)
  ) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_end_i  (bit_end),
    .bck_hi_i   (bck_hi),
    .frame_end_o(frame_end),
    .bck_o      (bck_o),
    .lrck_o     (lrck_o)
  );

endmodule

// File: tb/aud_clk_div_tb.sv
module aud_clk_div_tb;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] rate_mode = 2'b10;
  logic       bck, lrck, err;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  aud_clk_div u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .rate_mode_i(rate_mode),
    .bck_o      (bck),
    .lrck_o     (lrck),
    .mode_err_o (err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Measures one whole frame starting at the next lrck falling edge.
  // If chg_at > 0, rate_mode is set to chg_code that many cycles into the frame.
  task automatic measure_frame(input int chg_at, input logic [1:0] chg_code,
                               output int lo, output int hi, output int rises,
                               output int bmin, output int bmax, output int mis);
    logic pl, pb;
    int   run, guard;
    pl = lrck; guard = 0;
    forever begin
      @(negedge clk);
      guard++;
      if ((pl && !lrck) || guard > 5000) break;
      pl = lrck;
    end
    lo = 1; hi = 0; rises = 0; bmin = 9999; bmax = 0; mis = 0; run = 0;
    pl = lrck; pb = bck;
    forever begin
      @(negedge clk);
      if (lrck != pl && !(pb && !bck)) mis++;
      if (pb && !bck) begin
        if (run < bmin) bmin = run;
        if (run > bmax) bmax = run;
        run = 0;
      end
      if (!pb && bck) rises++;
      if (pl && !lrck) break;
      if (lo + hi > 5000) break;
      if (bck) run++;
      if (lrck) hi++; else lo++;
      if (chg_at > 0 && lo + hi == chg_at) rate_mode = chg_code;
      pl = lrck; pb = bck;
    end
  endtask

  task automatic check_frame(input string req, input int d, input int chg_at,
                             input logic [1:0] chg_code);
    int lo, hi, rises, bmin, bmax, mis;
    measure_frame(chg_at, chg_code, lo, hi, rises, bmin, bmax, mis);
    chk(req, "left half length", lo, 32 * d);
    chk(req, "right half length", hi, 32 * d);
    chk(req, "bck rises per frame", rises, 64);
    chk(req, "bck shortest high", bmin, d / 2);
    chk(req, "bck longest high", bmax, d / 2);
    chk("R5", "lrck edges off bck fall", mis, 0);
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "bck in reset", int'(bck), 0);
    chk("R1", "lrck in reset", int'(lrck), 0);
    chk("R1", "err in reset", int'(err), 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_rate(input string req, input int d);
    check_frame(req, d, 0, 2'b00);
    check_frame("R4", d, 0, 2'b00);
  endtask

  task automatic t_switch(input logic [1:0] code, input int old_d, input int new_d);
    check_frame("R6", old_d, 100, code);   // frame in flight keeps old length
    chk("R7", "err after legal switch", int'(err), 0);
    check_frame("R6", new_d, 0, 2'b00);
    chk("R7", "err one frame later", int'(err), 0);
  endtask

  task automatic t_illegal(input logic [1:0] code, input int keep_d);
    @(negedge clk);
    rate_mode = code;
    @(negedge clk);
    chk("R8", "err after illegal change", int'(err), 1);
    check_frame("R8", keep_d, 0, 2'b00);
  endtask

  task automatic t_sticky_reload;
    @(negedge clk);
    rate_mode = 2'b00;
    @(negedge clk);
    chk("R9", "err held on second illegal", int'(err), 1);
    rate_mode = 2'b11;
    @(negedge clk);
    chk("R9", "err cleared by reload", int'(err), 0);
    check_frame("R9", 4, 0, 2'b00);
  endtask

  task automatic t_reset_clears;
    @(negedge clk);
    rate_mode = 2'b01;
    @(negedge clk);
    chk("R8", "err before reset", int'(err), 1);
    rate_mode = 2'b10;
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R10", "err cleared by reset", int'(err), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R10", "err after reset release", int'(err), 0);
    check_frame("R1", 8, 0, 2'b00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_rate("R2", 8);
    t_switch(2'b11, 8, 4);
    t_rate("R3", 4);
    t_switch(2'b10, 4, 8);
    t_illegal(2'b01, 8);
    t_sticky_reload();
    t_illegal(2'b00, 4);
    t_reset_clears();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule